// File: doc/BRIEF.md
# Grouped Error Interrupt Status Controller

This block collects error events and device interrupt lines into one 32-bit status word. The low byte of the word mirrors eight level-sensitive device interrupt lines. Bits 8 to 30 are sticky error causes, and each is set by a one-cycle event pulse from the logic that detects it. Bit 31 records that a second error arrived while an earlier one was still pending. An enable word uses the same bit positions and selects which status bits drive the single interrupt output. A fixed subset of causes is classed as fatal and drives a separate output, whatever the enable word holds.

Software reaches the block through a small synchronous register port. Status is read-only. The enable word and a line-to-device map are read-write. A write-only group reset register clears error causes by group, one request bit per group, and cannot clear them one bit at a time. The map gives each interrupt line a 3-bit device number, with line n stored at bit position 3n.

Top module: `intr_group_ctrl`

## Requirements
- R1: After a synchronous reset, the status, enable and map registers read 0, and irq_o, fatal_o and multi_err_o are low.
- R2: A 1 on evt_i bit b, for b from 8 to 30, sets status bit b at the next clock edge. The bit then stays set until its group is cleared.
- R3: Writing the group reset register (reg_addr_i = 2) clears the cause bits of each requested group at the next edge, as follows. Request bit 0 clears bits 8 and 10–15. Request bit 1 clears bits 16 and 30. Request bit 2 clears bits 17–21. Request bit 3 clears bits 23, 24, 25 and 27. Request bit 4 clears bits 9, 26 and 28. Request bit 5 clears bits 22 and 29. Request bit 6 clears bit 31. The value 0x7F clears every cause.
- R4: When an event and a clear of the same bit occur in the same cycle, the bit ends up set.
- R5: Status bit 31, which is also multi_err_o, is set at the next edge when an error event arrives while any cause bit from 8 to 30 is already set. A first event into an empty status does not set it.
- R6: Status bits 7:0 show dev_irq_i as sampled at the previous edge. They are not sticky.
- R7: irq_o is high exactly when some status bit is set whose enable bit is also set. The enable register sits at reg_addr_i = 1.
- R8: fatal_o is high exactly when any of status bits 13, 14 or 22–29 is set. The enable word has no effect on it.
- R9: The map register at reg_addr_i = 3 holds 24 bits, with line n's device number in bits 3n+2:3n. Bits 31:24 read as 0. The group reset register reads as 0. A write to the status address (reg_addr_i = 0) has no effect.
- R10: evt_i bits 7:0 and bit 31 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 32 | Error event pulses, one per cause bit position |
| dev_irq_i | input | 8 | Level-sensitive device interrupt lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 status, 1 enable, 2 group reset, 3 map |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Interrupt output |
| fatal_o | output | 1 | Fatal-class error pending |
| multi_err_o | output | 1 | Multiple-error indication |

## Verification
The bench builds the block with its default parameters: eight interrupt lines with 3-bit device numbers. This gives the full 24-bit map, so every line's field position and the unused top byte can be checked. With the full line count, the device byte and the cause bits share the one status word, so device line changes and error causes can be checked against each other in the same readback. Random traffic mixes sparse events, group resets and enable changes. These reach the set-versus-clear collisions and the arrivals of a second error that the directed cases pin down.

// File: rtl/intr_pkg.sv
`timescale 1ns/1ps
package intr_pkg;
    localparam int REG_W     = 32;
    localparam int ADDR_W    = 2;
    localparam int GRP_N     = 7;
    localparam int MULTI_POS = 31;

    localparam logic [REG_W-1:0] CAUSE_MASK = 32'h7FFF_FF00;
    localparam logic [REG_W-1:0] FATAL_MASK = 32'h3FC0_6000;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_GRPRST = 2'd2,
        SEL_DEVMAP = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             en_we;
        logic             map_we;
        logic             grp_we;
        logic [REG_W-1:0] data;
    } reg_wr_s;

    function automatic logic [REG_W-1:0] group_bits(input int g);
        logic [REG_W-1:0] m;
        m = '0;
        case (g)
            0: m = 32'h0000_FD00;
            1: m = 32'h4001_0000;
            2: m = 32'h003E_0000;
            3: m = 32'h0B80_0000;
            4: m = 32'h1400_0200;
            5: m = 32'h2040_0000;
            6: m = 32'h8000_0000;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [REG_W-1:0] clear_mask(input logic [GRP_N-1:0] req);
        logic [REG_W-1:0] m;
        m = '0;
        for (int g = 0; g < GRP_N; g++) begin
            if (req[g]) m = m | group_bits(g);
        end
        return m;
    endfunction
endpackage

// File: rtl/intr_reg_decode.sv
`timescale 1ns/1ps
module intr_reg_decode
    import intr_pkg::*;
(
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output reg_wr_s           strobes
);
    reg_sel_e sel;

    always_comb begin
        sel             = reg_sel_e'(addr);
        strobes.data    = wdata;
        strobes.en_we   = wr && (sel == SEL_ENABLE);
        strobes.map_we  = wr && (sel == SEL_DEVMAP);
        strobes.grp_we  = wr && (sel == SEL_GRPRST);
    end
endmodule

// File: rtl/intr_cause_bank.sv
`timescale 1ns/1ps
module intr_cause_bank
    import intr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] evt,
    input  logic             grp_we,
    input  logic [GRP_N-1:0] grp_req,
    output logic [REG_W-1:0] cause_q,
    output logic             multi_q
);
    logic [REG_W-1:0] clr;
    logic [REG_W-1:0] evt_valid;
    logic             any_evt;
    logic             any_pending;

    always_comb begin
        clr         = grp_we ? clear_mask(grp_req) : '0;
        evt_valid   = evt & CAUSE_MASK;
        any_evt     = |evt_valid;
        any_pending = |(cause_q & CAUSE_MASK);
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (CAUSE_MASK[i]) begin : g_sticky
            always_ff @(posedge clk) begin
                if (rst)              cause_q[i] <= 1'b0;
                else if (evt_valid[i]) cause_q[i] <= 1'b1;
                else if (clr[i])      cause_q[i] <= 1'b0;
            end
        end else begin : g_none
            assign cause_q[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                          multi_q <= 1'b0;
        else if (any_evt && any_pending)  multi_q <= 1'b1;
        else if (clr[MULTI_POS])          multi_q <= 1'b0;
    end
endmodule

// File: rtl/intr_line_map.sv
`timescale 1ns/1ps
module intr_line_map #(
    parameter int LINES = 8,
    parameter int DEV_W = 3,
    localparam int MAP_W = LINES * DEV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] lines_in,
    input  logic             map_we,
    input  logic [MAP_W-1:0] map_wdata,
    output logic [LINES-1:0] lines_q,
    output logic [MAP_W-1:0] map_q
);
    always_ff @(posedge clk) begin
        if (rst) lines_q <= '0;
        else     lines_q <= lines_in;
    end

    for (genvar n = 0; n < LINES; n++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst)         map_q[n*DEV_W +: DEV_W] <= '0;
            else if (map_we) map_q[n*DEV_W +: DEV_W] <= map_wdata[n*DEV_W +: DEV_W];
        end
    end
endmodule

// File: rtl/intr_group_ctrl.sv
`timescale 1ns/1ps
module intr_group_ctrl
    import intr_pkg::*;
#(
    parameter int LINES = 8,
    parameter int DEV_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  evt_i,
    input  logic [LINES-1:0]  dev_irq_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o,
    output logic              fatal_o,
    output logic              multi_err_o
);
    localparam int MAP_W = LINES * DEV_W;

    reg_wr_s          strobes;
    logic [REG_W-1:0] cause_q;
    logic             multi_q;
    logic [LINES-1:0] lines_q;
    logic [MAP_W-1:0] map_q;
    logic [REG_W-1:0] enable_q;
    logic [REG_W-1:0] status_q;

    intr_reg_decode u_decode (
        .wr      (reg_wr_i),
        .addr    (reg_addr_i),
        .wdata   (reg_wdata_i),
        .strobes (strobes)
    );

    intr_cause_bank u_causes (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt_i),
        .grp_we  (strobes.grp_we),
        .grp_req (strobes.data[GRP_N-1:0]),
        .cause_q (cause_q),
        .multi_q (multi_q)
    );

    intr_line_map #(.LINES(LINES), .DEV_W(DEV_W)) u_lines (
        .clk       (clk),
        .rst       (rst),
        .lines_in  (dev_irq_i),
        .map_we    (strobes.map_we),
        .map_wdata (strobes.data[MAP_W-1:0]),
        .lines_q   (lines_q),
        .map_q     (map_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                enable_q <= '0;
        else if (strobes.en_we) enable_q <= strobes.data;
    end

    always_comb begin
        status_q                = cause_q;
        status_q[MULTI_POS]     = multi_q;
        status_q[LINES-1:0]     = lines_q;
    end

    always_comb begin
        case (reg_sel_e'(reg_addr_i))
            SEL_STATUS: reg_rdata_o = status_q;
            SEL_ENABLE: reg_rdata_o = enable_q;
            SEL_DEVMAP: reg_rdata_o = {{(REG_W-MAP_W){1'b0}}, map_q};
            default:    reg_rdata_o = '0;
        endcase
    end

    assign irq_o       = |(status_q & enable_q);
    assign fatal_o     = |(status_q & FATAL_MASK);
    assign multi_err_o = status_q[MULTI_POS];
endmodule

// File: rtl/intr_group_chk.sv
`timescale 1ns/1ps
module intr_group_chk
    import intr_pkg::*;
#(
    parameter int LINES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [REG_W-1:0]  evt_i,
    input logic [LINES-1:0]  dev_irq_i,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [REG_W-1:0]  reg_wdata_i,
    input logic [REG_W-1:0]  status_q,
    input logic [REG_W-1:0]  enable_q,
    input logic              irq_o
);
    logic [REG_W-1:0] chk_clr;
    logic [REG_W-1:0] chk_evt;

    always_comb begin
        chk_clr = (reg_wr_i && reg_addr_i == 2'd2) ? clear_mask(reg_wdata_i[GRP_N-1:0]) : '0;
        chk_evt = evt_i & CAUSE_MASK;
    end

    // R2, R4: an event always lands, even under a clear
    assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (chk_evt != '0) |=> ((status_q & $past(chk_evt)) == $past(chk_evt)));

    // R3: a cause bit only falls inside a requested group
    assert_clear_by_group_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(status_q) & ~status_q & (CAUSE_MASK | 32'h8000_0000)) & ~$past(chk_clr)) == '0));

    // R5: multiple-error rises only on a second pending error
    assert_multi_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q[MULTI_POS]) |-> ($past(chk_evt != '0) && $past((status_q & CAUSE_MASK) != '0)));

    // R6: device bits follow the lines one cycle later
    assert_lines_follow_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status_q[LINES-1:0] == $past(dev_irq_i)));

    // R7: nothing enabled means no interrupt
    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        (enable_q == '0) |-> !irq_o);
endmodule

bind intr_group_ctrl intr_group_chk #(.LINES(LINES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt_i       (evt_i),
    .dev_irq_i   (dev_irq_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .status_q    (status_q),
    .enable_q    (enable_q),
    .irq_o       (irq_o)
);

// File: tb/test_intr_group_ctrl.sv
`timescale 1ns/1ps
module test_intr_group_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt = '0;
    logic [7:0]  dev = '0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fatal, multi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_st = '0, m_en = '0;
    logic [23:0] m_map = '0;
    logic [31:0] last_rd;
    logic        last_irq, last_fatal, last_multi;

    always #2.5 clk = ~clk;

    intr_group_ctrl i_intr_group_ctrl (
        .clk(clk), .rst(rst), .evt_i(evt), .dev_irq_i(dev),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .fatal_o(fatal), .multi_err_o(multi)
    );

    function automatic logic [31:0] grp_clr(input logic [6:0] r);
        logic [31:0] m = '0;
        if (r[0]) m |= 32'h0000_FD00;
        if (r[1]) m |= 32'h4001_0000;
        if (r[2]) m |= 32'h003E_0000;
        if (r[3]) m |= 32'h0B80_0000;
        if (r[4]) m |= 32'h1400_0200;
        if (r[5]) m |= 32'h2040_0000;
        if (r[6]) m |= 32'h8000_0000;
        return m;
    endfunction

    function automatic logic [31:0] next_st(input logic [31:0] st, input logic [31:0] e,
                                            input logic [7:0] d, input logic w,
                                            input logic [1:0] a, input logic [31:0] wd);
        logic [31:0] c, ev, n;
        c  = (w && a == 2'd2) ? grp_clr(wd[6:0]) : 32'h0;
        ev = e & 32'h7FFF_FF00;
        n  = ((st & ~c) | ev) & 32'h7FFF_FF00;
        n[31] = (st[31] & ~c[31]) | ((ev != 0) && ((st & 32'h7FFF_FF00) != 0));
        n[7:0] = d;
        return n;
    endfunction

    function automatic logic [31:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_st;
            2'd1: return m_en;
            2'd3: return {8'h00, m_map};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [31:0] e, input logic [7:0] d, input logic w,
                       input logic [1:0] a, input logic [31:0] wd);
        @(negedge clk);
        evt = e; dev = d; wr = w; addr = a; wdata = wd;
        #1;
        last_rd = rdata; last_irq = irq; last_fatal = fatal; last_multi = multi;
        check((a == 2'd0) ? "R2 status readback" : "R9 register readback", rdata, model_read(a));
        check("R7 irq", {31'b0, irq}, {31'b0, |(m_st & m_en)});
        check("R8 fatal", {31'b0, fatal}, {31'b0, |(m_st & 32'h3FC0_6000)});
        check("R5 multi", {31'b0, multi}, {31'b0, m_st[31]});
        @(posedge clk);
        m_st = next_st(m_st, e, d, w, a, wd);
        if (w && a == 2'd1) m_en = wd;
        if (w && a == 2'd3) m_map = wd[23:0];
    endtask

    task automatic rd(input logic [1:0] a);
        cyc(32'h0, dev, 1'b0, a, 32'h0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [23:0] pat;
        void'($urandom(32'd12345));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd(2'd0); check("R1 status", last_rd, 32'h0);
        check("R1 outputs", {29'b0, last_irq, last_fatal, last_multi}, 32'h0);
        rd(2'd1); check("R1 enable", last_rd, 32'h0);
        rd(2'd3); check("R1 map", last_rd, 32'h0);

        // R10 ignored event positions
        cyc(32'h8000_00FF, 8'h0, 1'b0, 2'd0, 32'h0);
        rd(2'd0); check("R10 ignored events", last_rd, 32'h0);

        // R2 sticky set, R5 no multi on first error
        cyc(32'h0001_0000, 8'h0, 1'b0, 2'd0, 32'h0);
        rd(2'd0); check("R2 set bit16", last_rd, 32'h0001_0000);
        rd(2'd0); check("R2 sticky", last_rd, 32'h0001_0000);
        check("R5 no multi first", {31'b0, last_multi}, 32'h0);

        // R5 second error sets multi
        cyc(32'h0000_0200, 8'h0, 1'b0, 2'd0, 32'h0);
        rd(2'd0); check("R5 multi set", last_rd, 32'h8001_0200);
        check("R5 multi out", {31'b0, last_multi}, 32'h1);
        check("R8 not fatal", {31'b0, last_fatal}, 32'h0);

        // R8 fatal
        cyc(32'h0000_2000, 8'h0, 1'b0, 2'd0, 32'h0);
        rd(2'd0); check("R8 fatal on bit13", {31'b0, last_fatal}, 32'h1);
        check("R7 irq off with no enable", {31'b0, last_irq}, 32'h0);

        // R7 enable
        cyc(32'h0, 8'h0, 1'b1, 2'd1, 32'h0000_0200);
        rd(2'd0); check("R7 irq enabled", {31'b0, last_irq}, 32'h1);
        cyc(32'h0, 8'h0, 1'b1, 2'd1, 32'h0000_00FF);
        rd(2'd0); check("R7 irq masked", {31'b0, last_irq}, 32'h0);

        // R3 group clears
        cyc(32'h0, 8'h0, 1'b1, 2'd2, 32'h10);
        rd(2'd0); check("R3 group4", last_rd, 32'h8001_2000);
        cyc(32'h0, 8'h0, 1'b1, 2'd2, 32'h01);
        rd(2'd0); check("R3 group0", last_rd, 32'h8001_0000);
        check("R8 fatal cleared", {31'b0, last_fatal}, 32'h0);
        cyc(32'h0, 8'h0, 1'b1, 2'd2, 32'h40);
        rd(2'd0); check("R3 group6", last_rd, 32'h0001_0000);
        cyc(32'h0, 8'h0, 1'b1, 2'd2, 32'h02);
        rd(2'd0); check("R3 group1", last_rd, 32'h0);

        // R4 set wins over clear
        cyc(32'h0002_0000, 8'h0, 1'b1, 2'd2, 32'h04);
        rd(2'd0); check("R4 set wins", last_rd, 32'h0002_0000);

        // R6 device lines
        cyc(32'h0, 8'hA5, 1'b0, 2'd0, 32'h0);
        cyc(32'h0, 8'h00, 1'b0, 2'd0, 32'h0);
        check("R6 lines sampled", last_rd, 32'h0002_00A5);
        check("R7 irq from line", {31'b0, last_irq}, 32'h1);
        rd(2'd0); check("R6 not sticky", last_rd, 32'h0002_0000);

        // R9 map, reset reg read, status write ignored
        cyc(32'h0, 8'h0, 1'b1, 2'd3, 32'hFFFF_FFFF);
        rd(2'd3); check("R9 map width", last_rd, 32'h00FF_FFFF);
        pat = '0;
        for (int n = 0; n < 8; n++) pat[3*n +: 3] = 3'(n);
        cyc(32'h0, 8'h0, 1'b1, 2'd3, {8'h0, pat});
        rd(2'd3); check("R9 map fields", last_rd, 32'h00FA_C688);
        rd(2'd2); check("R9 reset reads zero", last_rd, 32'h0);
        cyc(32'h0, 8'h0, 1'b1, 2'd0, 32'hFFFF_FFFF);
        rd(2'd0); check("R9 status write ignored", last_rd, 32'h0002_0000);

        // R3 clear all
        cyc(32'h7FFF_FF00, 8'h0, 1'b0, 2'd0, 32'h0);
        cyc(32'h0000_0100, 8'h0, 1'b0, 2'd0, 32'h0);
        rd(2'd0); check("R3 all set", last_rd, 32'hFFFF_FF00);
        cyc(32'h0, 8'h0, 1'b1, 2'd2, 32'h7F);
        rd(2'd0); check("R3 clear all", last_rd, 32'h0);

        // random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] e, wd;
            logic        w;
            logic [1:0]  a;
            e  = ($urandom % 6 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
            w  = ($urandom % 5 == 0);
            a  = 2'($urandom);
            wd = $urandom;
            if (a == 2'd2 && ($urandom % 2 == 0)) wd = 32'h1 << ($urandom % 7);
            cyc(e, 8'($urandom), w, a, wd);
        end

        finish_run();
    end
endmodule